// File: doc/BRIEF.md
# Feedback Divider with Test Observation Mux

This block holds the loop-side counting logic of a frequency synthesizer and the logic that picks what a single test pin shows. A 9-bit programmable down counter divides the high-speed clock by a modulus M and emits a one-cycle pulse once per period. That pulse is the feedback that a phase comparator outside this block consumes. A 3-bit select chooses one of eight sources for a registered test output. The sources are a constant high or low, the serial configuration bit stream, the reference clock, the feedback pulse, the main divided output, and that main output divided by a further four.

One select code puts the block into bypass. The slow serial clock then replaces the high-speed clock as the count source of the feedback counter. A power-of-two output divider, also driven by the serial clock, takes over the main output pin, and the test pin shows the feedback pulse. Bypass lets board-level debug step the clock tree by hand. The parallel-load strobe, while low, acts as a reset of the test-select latch. In that state the select is forced to the serial-stream code and bypass cannot engage.

The block runs entirely on `clk`, which is the high-speed clock. The serial clock, reference clock, main divided output and serial stream bit arrive as levels and are sampled in that domain.

Top module: `fbk_div_tmux`

## Requirements
- R1: Outside bypass, with M of 2 or more, `m_pulse` is high for exactly one `clk` cycle in every M cycles. For example, M = 262 is given on `m_val` as 100000110, with bit 8 as the MSB.
- R2: A modulus of 0 or 1 is treated as divide-by-one: once the counter reaches its terminal state, `m_pulse` stays high continuously.
- R3: A new `m_val` takes effect at the next terminal count, when the counter reloads with M−1. The period in progress finishes with the old modulus.
- R4: Effective select 000 makes `test_out` follow `sr_bit`, 001 drives it high and 101 drives it low. `test_out` updates one `clk` cycle after the select and its source are sampled.
- R5: Effective select 010 routes `ref_clk`, 011 routes `m_pulse` and 100 routes `main_div` to `test_out`, each with one cycle of register delay.
- R6: Effective select 111 shows bit 1 of a 2-bit counter of `main_div` rising edges, which divides `main_div` by four. Each edge is detected two `clk` cycles after it arrives.
- R7: Select 110 (bypass) makes the feedback counter advance only on rising edges of `sclk`, detected through a two-stage sampler. The counter holds its value on all other cycles, and `test_out` shows `m_pulse`.
- R8: In bypass, `fout` is `sclk` divided by 2^`n_sel`. For `n_sel`=0 this is the first sampled `sclk`; otherwise it is bit `n_sel`−1 of a free-running 3-bit count of `sclk` rising edges. Outside bypass, `fout` equals `main_div` combinationally.
- R9: While `pload` is low, the effective select is 000, so `test_out` shows `sr_bit` and bypass is off, whatever `tsel` holds.
- R10: During and right after reset, `test_out` is 0 and `m_pulse` is 1, because the counter starts at its terminal state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | High-speed clock; counts the feedback divider outside bypass |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock level; count source in bypass |
| ref_clk | input | 1 | Reference clock level for observation |
| main_div | input | 1 | Main divided output from the output divider |
| sr_bit | input | 1 | Serial-out bit of the configuration shift register |
| pload | input | 1 | Parallel-load strobe; low forces select 000 |
| tsel | input | 3 | Test select field |
| m_val | input | 9 | Feedback modulus M, bit 8 MSB |
| n_sel | input | 2 | Bypass output divide exponent (1, 2, 4, 8) |
| m_pulse | output | 1 | Feedback pulse, one cycle per M counts |
| fout | output | 1 | Main output: main_div, or divided sclk in bypass |
| test_out | output | 1 | Registered test observation output |

## Verification
If the feedback count state is wrong, the spacing of `m_pulse` pulses changes at the first terminal count after the fault. A bad reload shows as a period that differs from M within one period. A fault in the bypass gating shows as pulses that advance without `sclk` edges within M serial edges. A wrong select decode or latch reset appears on `test_out` one cycle after the select is applied. Faults in either divide counter reach `fout` or `test_out` after one or two source edges.

// File: rtl/fbk_div_pkg.sv
package fbk_div_pkg;

  typedef enum logic [2:0] {
    TS_SHIFT  = 3'b000,
    TS_HIGH   = 3'b001,
    TS_REF    = 3'b010,
    TS_MCNT   = 3'b011,
    TS_MAIN   = 3'b100,
    TS_LOW    = 3'b101,
    TS_BYPASS = 3'b110,
    TS_MAINQ  = 3'b111
  } tsel_e;

endpackage

// File: rtl/fbk_mcount.sv
module fbk_mcount #(
  parameter int M_W = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [M_W-1:0] m_val,
  output logic [M_W-1:0] cnt_o,
  output logic           pulse_o
);
  logic [M_W-1:0] cnt_q, cnt_d;
  logic           small_m;

  assign small_m = (m_val <= M_W'(1));

  // next state: count down on tick, reload M-1 at terminal count
  always_comb begin
    cnt_d = cnt_q;
    if (tick) begin
      if (cnt_q == '0) begin
        cnt_d = small_m ? '0 : (m_val - M_W'(1));
      end else begin
        cnt_d = cnt_q - M_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o   = cnt_q;
  assign pulse_o = (cnt_q == '0);
endmodule

// File: rtl/fbk_edge_div.sv
module fbk_edge_div #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl,
  output logic          smp_o,
  output logic          rise_o,
  output logic [CW-1:0] cnt_o
);
  logic          q1_q, q2_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rise;

  assign rise = q1_q & ~q2_q;

  always_comb begin
    cnt_d = cnt_q;
    if (rise) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1_q  <= 1'b0;
      q2_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      q1_q  <= lvl;
      q2_q  <= q1_q;
      cnt_q <= cnt_d;
    end
  end

  assign smp_o  = q1_q;
  assign rise_o = rise;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/fbk_pow2_pick.sv
module fbk_pow2_pick #(
  parameter int CW = 3,
  parameter int SW = 2
) (
  input  logic          base,
  input  logic [CW-1:0] cnt,
  input  logic [SW-1:0] sel,
  output logic          out
);
  localparam int NTAP = 1 << SW;
  logic [NTAP-1:0] taps;

  assign taps[0] = base;
  for (genvar k = 1; k < NTAP; k++) begin : g_tap
    if (k <= CW) begin : g_bit
      assign taps[k] = cnt[k-1];
    end else begin : g_pad
      assign taps[k] = cnt[CW-1];
    end
  end

  assign out = taps[sel];
endmodule

// File: rtl/fbk_test_mux.sv
module fbk_test_mux
  import fbk_div_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  tsel_e eff_t,
  input  logic  sr_bit,
  input  logic  ref_clk,
  input  logic  m_pulse,
  input  logic  main_div,
  input  logic  main_q,
  output logic  test_o
);
  logic pick_d, test_q;

  always_comb begin
    unique case (eff_t)
      TS_SHIFT:  pick_d = sr_bit;
      TS_HIGH:   pick_d = 1'b1;
      TS_REF:    pick_d = ref_clk;
      TS_MCNT:   pick_d = m_pulse;
      TS_MAIN:   pick_d = main_div;
      TS_LOW:    pick_d = 1'b0;
      TS_BYPASS: pick_d = m_pulse;
      TS_MAINQ:  pick_d = main_q;
      default:   pick_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) test_q <= 1'b0;
    else        test_q <= pick_d;
  end

  assign test_o = test_q;
endmodule

// File: rtl/fbk_div_tmux.sv
module fbk_div_tmux
  import fbk_div_pkg::*;
#(
  parameter int M_W      = 9,
  parameter int N_W      = 2,
  parameter int AUX_LOG2 = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sclk,
  input  logic           ref_clk,
  input  logic           main_div,
  input  logic           sr_bit,
  input  logic           pload,
  input  logic [2:0]     tsel,
  input  logic [M_W-1:0] m_val,
  input  logic [N_W-1:0] n_sel,
  output logic           m_pulse,
  output logic           fout,
  output logic           test_out
);
  localparam int NCW = (1 << N_W) - 1;

  tsel_e          eff_t;
  logic           bypass;
  logic           mc_tick;
  logic [M_W-1:0] mc_cnt;
  logic           s_smp, s_rise, n_tap;
  logic [NCW-1:0] s_cnt;
  logic           a_smp, a_rise;
  logic [AUX_LOG2-1:0] a_cnt;

  // latch reset: low strobe forces the serial-stream code
  assign eff_t   = pload ? tsel_e'(tsel) : TS_SHIFT;
  assign bypass  = (eff_t == TS_BYPASS);
  assign mc_tick = bypass ? s_rise : 1'b1;

  fbk_mcount #(.M_W(M_W)) u_mcnt (
    .clk(clk), .rst_n(rst_n), .tick(mc_tick), .m_val(m_val),
    .cnt_o(mc_cnt), .pulse_o(m_pulse)
  );

  fbk_edge_div #(.CW(NCW)) u_sdiv (
    .clk(clk), .rst_n(rst_n), .lvl(sclk),
    .smp_o(s_smp), .rise_o(s_rise), .cnt_o(s_cnt)
  );

  fbk_pow2_pick #(.CW(NCW), .SW(N_W)) u_npick (
    .base(s_smp), .cnt(s_cnt), .sel(n_sel), .out(n_tap)
  );

  fbk_edge_div #(.CW(AUX_LOG2)) u_adiv (
    .clk(clk), .rst_n(rst_n), .lvl(main_div),
    .smp_o(a_smp), .rise_o(a_rise), .cnt_o(a_cnt)
  );

  fbk_test_mux u_tmux (
    .clk(clk), .rst_n(rst_n), .eff_t(eff_t), .sr_bit(sr_bit),
    .ref_clk(ref_clk), .m_pulse(m_pulse), .main_div(main_div),
    .main_q(a_cnt[AUX_LOG2-1]), .test_o(test_out)
  );

  assign fout = bypass ? n_tap : main_div;
endmodule

// File: rtl/fbk_div_tmux_chk.sv
module fbk_div_tmux_chk #(
  parameter int M_W = 9
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pload,
  input logic [2:0]     tsel,
  input logic [M_W-1:0] m_val,
  input logic           sr_bit,
  input logic           main_div,
  input logic           m_pulse,
  input logic           fout,
  input logic           test_out,
  input logic           mc_tick,
  input logic [M_W-1:0] mc_cnt
);
  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (m_pulse && mc_tick && m_val >= M_W'(2)) |=> !m_pulse);

  p_small_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_pulse && m_val <= M_W'(1)) |=> m_pulse);

  p_force_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pload && tsel == 3'b001) |=> test_out);

  p_force_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pload && tsel == 3'b101) |=> !test_out);

  p_no_tick_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_tick |=> $stable(mc_cnt));

  p_pass_main_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(pload && tsel == 3'b110) |-> (fout == main_div));

  p_load_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pload |=> (test_out == $past(sr_bit)));
endmodule

bind fbk_div_tmux fbk_div_tmux_chk #(.M_W(M_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pload(pload), .tsel(tsel), .m_val(m_val),
  .sr_bit(sr_bit), .main_div(main_div), .m_pulse(m_pulse), .fout(fout),
  .test_out(test_out), .mc_tick(mc_tick), .mc_cnt(mc_cnt)
);

// File: tb/fbk_div_tmux_tb.sv
`timescale 1ns/1ps
module fbk_div_tmux_tb;
  logic clk, rst_n, sclk, ref_clk, main_div, sr_bit, pload;
  logic [2:0] tsel;
  logic [8:0] m_val;
  logic [1:0] n_sel;
  logic m_pulse, fout, test_out;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  string cur_req = "R1";

  // reference state
  bit s1, s2, fm1, fm2, tq;
  logic [8:0] mc;
  logic [2:0] nc;
  logic [1:0] ax;
  int last_pulse = -1;
  bit prev_mp = 0;
  bit per_on = 0;

  fbk_div_tmux u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .ref_clk(ref_clk),
    .main_div(main_div), .sr_bit(sr_bit), .pload(pload), .tsel(tsel),
    .m_val(m_val), .n_sel(n_sel), .m_pulse(m_pulse), .fout(fout),
    .test_out(test_out)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic string tag_of(input logic [2:0] t, input logic pl);
    if (!pl) return "R9";
    case (t)
      3'd0, 3'd1, 3'd5: return "R4";
      3'd2, 3'd3, 3'd4: return "R5";
      3'd7:             return "R6";
      default:          return "R7";
    endcase
  endfunction

  function automatic bit exp_fout();
    if (pload && tsel == 3'b110) return (n_sel == 0) ? s1 : nc[n_sel-1];
    return main_div;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  task automatic model_step();
    logic [2:0] et;
    bit byp, rise, mp, sv;
    if (!rst_n) begin
      s1 = 0; s2 = 0; fm1 = 0; fm2 = 0; tq = 0; mc = 0; nc = 0; ax = 0;
      return;
    end
    et   = pload ? tsel : 3'b000;
    byp  = (et == 3'b110);
    rise = s1 & ~s2;
    mp   = (mc == 0);
    case (et)
      3'd0: sv = sr_bit;
      3'd1: sv = 1;
      3'd2: sv = ref_clk;
      3'd3: sv = mp;
      3'd4: sv = main_div;
      3'd5: sv = 0;
      3'd6: sv = mp;
      default: sv = ax[1];
    endcase
    if (fm1 & ~fm2) ax = ax + 1;
    if (rise) nc = nc + 1;
    if (!byp || rise) begin
      if (mc == 0) mc = (m_val <= 1) ? 9'd0 : m_val - 9'd1;
      else         mc = mc - 1;
    end
    s2 = s1; s1 = sclk; fm2 = fm1; fm1 = main_div; tq = sv;
  endtask

  // one clock: model at the edge, compare at the following falling edge
  task automatic step();
    string tt;
    tt = tag_of(tsel, pload);
    @(posedge clk);
    model_step();
    @(negedge clk);
    cyc++;
    chk(cur_req, m_pulse, (mc == 0));
    chk(tt, test_out, tq);
    chk("R8", fout, exp_fout());
    if (per_on && m_pulse && !prev_mp) begin
      if (last_pulse >= 0) begin
        n_chk++;
        if (cyc - last_pulse != int'(m_val)) begin
          n_bad++;
          $display("FAIL R1 period: actual %0d expected %0d", cyc - last_pulse, m_val);
        end
      end
      last_pulse = cyc;
    end
    prev_mp = m_pulse;
  endtask

  task automatic rand_levels();
    ref_clk  = 1'($urandom);
    main_div = 1'($urandom);
    sr_bit   = 1'($urandom);
    if ($urandom_range(0, 2) == 0) sclk = ~sclk;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; sclk = 0; ref_clk = 0; main_div = 0; sr_bit = 0;
    pload = 1; tsel = 3'd3; m_val = 9'd7; n_sel = 0;
    model_step();
    repeat (3) @(negedge clk);
    chk("R10", test_out, 1'b0);
    chk("R10", m_pulse, 1'b1);
    rst_n = 1;
    chk("R10", m_pulse, 1'b1);

    // R1: short and in-range moduli, period measured
    cur_req = "R1"; per_on = 1;
    repeat (60) begin rand_levels(); step(); end
    last_pulse = -1; m_val = 9'b100000110;
    repeat (800) begin rand_levels(); step(); end
    last_pulse = -1; m_val = 9'd200;
    repeat (700) begin rand_levels(); step(); end
    per_on = 0;

    // R2: divide-by-one
    cur_req = "R2"; m_val = 9'd1;
    repeat (300) begin rand_levels(); step(); end
    for (int i = 0; i < 20; i++) begin rand_levels(); step(); chk("R2", m_pulse, 1'b1); end
    m_val = 9'd0;
    for (int i = 0; i < 20; i++) begin rand_levels(); step(); chk("R2", m_pulse, 1'b1); end

    // R3: modulus change mid period
    cur_req = "R3"; m_val = 9'd12;
    repeat (17) begin rand_levels(); step(); end
    m_val = 9'd4;
    repeat (40) begin rand_levels(); step(); end
    m_val = 9'd9;
    repeat (3) begin rand_levels(); step(); end
    m_val = 9'd3;
    repeat (30) begin rand_levels(); step(); end

    // R4 R5 R6: random observation selects
    cur_req = "R1"; m_val = 9'd6;
    for (int i = 0; i < 800; i++) begin
      if (i % 7 == 0) begin
        tsel = 3'($urandom_range(0, 7));
        if (tsel == 3'd6) tsel = 3'd7;
      end
      rand_levels();
      if ($urandom_range(0, 3) == 0) main_div = ~main_div;
      step();
    end

    // R7 R8: bypass with each output divide
    cur_req = "R7";
    for (int n = 0; n < 4; n++) begin
      n_sel = 2'(n); tsel = 3'd6; m_val = 9'd5;
      repeat (250) begin rand_levels(); step(); end
    end

    // R9: strobe low overrides the select
    for (int i = 0; i < 600; i++) begin
      pload = ($urandom_range(0, 2) != 0);
      tsel  = 3'($urandom_range(0, 7));
      n_sel = 2'($urandom);
      if (i % 50 == 0) m_val = 9'($urandom_range(0, 9));
      cur_req = pload ? "R1" : "R9";
      rand_levels();
      step();
    end
    summary();
  end
endmodule